// File: doc/BRIEF.md
# Write-Invalidate Home Controller

This block sits at the home node of one shared memory word that several processors may hold in their caches. It keeps the directory of current holders. It also turns every incoming write into an ordered transaction. The word is locked first. Invalidations go out to every other holder, and the block waits until each one has answered. Then the home copy is rewritten, the lock is dropped, and only after that does the writer receive its completion notice. A writer that waits for that notice can rely on no other processor reading a stale value of the word.

Write and read requests enter on valid/ready channels. A request moves on a rising clock edge where both valid and ready are high. A requester that sees ready low must keep valid and its payload steady until ready returns. The write channel is ready only while the controller is idle. The read channel is ready whenever the word is not locked, except while a write is waiting in the idle state, because writes take priority. Invalidation requests, acknowledgements, the home-copy write strobe and the completion pulse are plain per-cycle signals without back-pressure. Node i owns bit i of every node vector.

Top module: `wih_home_ctrl`

## Requirements
- R1: After reset the controller is idle: wr_ready is 1, locked is 0, sharers is all zero, and inv_req, mem_we and wr_done are 0.
- R2: wr_ready is 1 only in the idle state. The cycle after a write is accepted, locked reads 1 and inv_req is still zero.
- R3: When other holders exist, inv_req is a one-cycle vector in the second cycle after acceptance. It equals the directory at acceptance with the writer's own bit cleared.
- R4: mem_we stays 0 until every targeted holder has raised its inv_ack bit. It rises in the cycle after the edge that samples the last outstanding acknowledgement.
- R5: An inv_ack bit from a node that has no outstanding invalidation is ignored, and the update timing does not change.
- R6: If no holder other than the writer exists, the invalidation step is skipped and mem_we is 1 in the second cycle after acceptance.
- R7: locked drops in the cycle after mem_we. wr_done is a one-cycle pulse one cycle later still, and wr_done_node carries the writer's ID.
- R8: After the home-copy update, sharers holds only the writer's bit.
- R9: rd_ready is 0 while locked and while a write is offered in the idle state. An accepted read sets the reader's bit in sharers.
- R10: While mem_we is 1, mem_wdata equals the data of the accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request offered |
| wr_ready | output | 1 | Write request can be taken |
| wr_node | input | NODE_W | ID of the writing node |
| wr_data | input | DATA_W | New value of the word |
| rd_valid | input | 1 | Read request offered |
| rd_ready | output | 1 | Read request can be taken |
| rd_node | input | NODE_W | ID of the reading node |
| inv_req | output | N_NODES | One-cycle invalidation request per node |
| inv_ack | input | N_NODES | Invalidation acknowledgement per node |
| mem_we | output | 1 | Write strobe for the home copy |
| mem_wdata | output | DATA_W | Data for the home copy |
| locked | output | 1 | Word is locked by a write in progress |
| sharers | output | N_NODES | Current directory of holders |
| wr_done | output | 1 | One-cycle completion pulse to the writer |
| wr_done_node | output | NODE_W | ID of the writer being acknowledged |

## Verification
Writes are tried in four situations: an empty directory, a directory that contains the writer, a directory without the writer, and a full directory. Comparing them shows whether the writer's own bit is excluded and whether the invalidation step is skipped when no one else holds the word. Acknowledgements come back with random per-node delays, so an update that fires early or late is caught. Acknowledgements from nodes with nothing outstanding are mixed in to show they have no effect. A read held against a write in progress shows the hold-off, the write priority, and the reader being recorded after the lock is released.

// File: rtl/wih_pkg.sv
package wih_pkg;
  typedef enum logic [2:0] {
    S_IDLE       = 3'd0,
    S_LOCK       = 3'd1,
    S_INVAL      = 3'd2,
    S_WAIT_ACK   = 3'd3,
    S_UPDATE     = 3'd4,
    S_RELEASE    = 3'd5,
    S_ACK_WRITER = 3'd6
  } wih_state_e;
endpackage

// File: rtl/wih_ack_tracker.sv
module wih_ack_tracker #(
  parameter int N_NODES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [N_NODES-1:0] load_vec,
  input  logic               ack_en,
  input  logic [N_NODES-1:0] ack,
  output logic [N_NODES-1:0] pending,
  output logic               pend_zero,
  output logic               pend_zero_next
);
  // One outstanding-acknowledgement flag per node.
  for (genvar i = 0; i < N_NODES; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pending[i] <= 1'b0;
      end else if (load) begin
        pending[i] <= load_vec[i];
      end else if (ack_en && ack[i]) begin
        pending[i] <= 1'b0;
      end
    end
  end

  assign pend_zero      = ~|pending;
  assign pend_zero_next = ~|(pending & ~(ack_en ? ack : '0));

  // Outside a load, flags may only clear; a stray ack cannot set one.
  assert_pending_no_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ((pending & ~$past(pending)) == '0));
endmodule

// File: rtl/wih_directory.sv
module wih_directory #(
  parameter int N_NODES = 4,
  parameter int NODE_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_fire,
  input  logic [NODE_W-1:0]  rd_node,
  input  logic               upd,
  input  logic [NODE_W-1:0]  upd_node,
  output logic [N_NODES-1:0] sharers
);
  localparam logic [N_NODES-1:0] ONE = {{(N_NODES-1){1'b0}}, 1'b1};

  logic [N_NODES-1:0] rd_mask, upd_mask;
  assign rd_mask  = ONE << rd_node;
  assign upd_mask = ONE << upd_node;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sharers <= '0;
    end else if (upd) begin
      sharers <= upd_mask;
    end else if (rd_fire) begin
      sharers <= sharers | rd_mask;
    end
  end

  assert_owner_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (sharers == $past(upd_mask)));
endmodule

// File: rtl/wih_seq.sv
module wih_seq
  import wih_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_fire,
  input  logic       pend_zero,
  input  logic       pend_zero_next,
  output wih_state_e state
);
  wih_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:       if (wr_fire) nxt = S_LOCK;
      S_LOCK:       nxt = pend_zero ? S_UPDATE : S_INVAL;
      S_INVAL:      nxt = S_WAIT_ACK;
      S_WAIT_ACK:   if (pend_zero_next) nxt = S_UPDATE;
      S_UPDATE:     nxt = S_RELEASE;
      S_RELEASE:    nxt = S_ACK_WRITER;
      S_ACK_WRITER: nxt = S_IDLE;
      default:      nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  assert_inval_after_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_INVAL) |-> ($past(state) == S_LOCK));
  assert_lock_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOCK) |-> $past(wr_fire));
endmodule

// File: rtl/wih_home_ctrl.sv
module wih_home_ctrl
  import wih_pkg::*;
#(
  parameter int N_NODES = 4,
  parameter int DATA_W  = 16,
  parameter int NODE_W  = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [NODE_W-1:0]  wr_node,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_valid,
  output logic               rd_ready,
  input  logic [NODE_W-1:0]  rd_node,
  output logic [N_NODES-1:0] inv_req,
  input  logic [N_NODES-1:0] inv_ack,
  output logic               mem_we,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               locked,
  output logic [N_NODES-1:0] sharers,
  output logic               wr_done,
  output logic [NODE_W-1:0]  wr_done_node
);
  localparam logic [N_NODES-1:0] ONE = {{(N_NODES-1){1'b0}}, 1'b1};

  wih_state_e         state;
  logic               wr_fire, rd_fire;
  logic               pend_zero, pend_zero_next;
  logic [N_NODES-1:0] pending, writer_mask, wr_mask_q;
  logic [NODE_W-1:0]  wr_id_q;
  logic [DATA_W-1:0]  data_q;

  assign wr_ready    = (state == S_IDLE);
  assign wr_fire     = wr_valid && wr_ready;
  assign locked      = (state == S_LOCK) || (state == S_INVAL) ||
                       (state == S_WAIT_ACK) || (state == S_UPDATE);
  assign rd_ready    = !locked && !(state == S_IDLE && wr_valid);
  assign rd_fire     = rd_valid && rd_ready;
  assign writer_mask = ONE << wr_node;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_id_q   <= '0;
      data_q    <= '0;
      wr_mask_q <= '0;
    end else if (wr_fire) begin
      wr_id_q   <= wr_node;
      data_q    <= wr_data;
      wr_mask_q <= writer_mask;
    end
  end

  wih_seq u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_fire        (wr_fire),
    .pend_zero      (pend_zero),
    .pend_zero_next (pend_zero_next),
    .state          (state)
  );

  wih_ack_tracker #(.N_NODES(N_NODES)) u_track (
    .clk            (clk),
    .rst_n          (rst_n),
    .load           (wr_fire),
    .load_vec       (sharers & ~writer_mask),
    .ack_en         ((state == S_INVAL) || (state == S_WAIT_ACK)),
    .ack            (inv_ack),
    .pending        (pending),
    .pend_zero      (pend_zero),
    .pend_zero_next (pend_zero_next)
  );

  wih_directory #(.N_NODES(N_NODES), .NODE_W(NODE_W)) u_dir (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_fire  (rd_fire),
    .rd_node  (rd_node),
    .upd      (state == S_UPDATE),
    .upd_node (wr_id_q),
    .sharers  (sharers)
  );

  assign inv_req      = (state == S_INVAL) ? pending : '0;
  assign mem_we       = (state == S_UPDATE);
  assign mem_wdata    = mem_we ? data_q : '0;
  assign wr_done      = (state == S_ACK_WRITER);
  assign wr_done_node = wr_id_q;

  assert_update_after_acks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> pend_zero);
  assert_inv_skips_writer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|inv_req) |-> ((inv_req & wr_mask_q) == '0));
  assert_release_after_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !locked);
  assert_done_after_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> $past(!locked && !mem_we && !wr_done));
  assert_read_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |-> !locked);
endmodule

// File: tb/tb_wih_home_ctrl.sv
module tb_wih_home_ctrl;
  localparam int N  = 4;
  localparam int DW = 16;
  localparam int NW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0, rd_valid = 1'b0;
  logic          wr_ready, rd_ready;
  logic [NW-1:0] wr_node = '0, rd_node = '0;
  logic [DW-1:0] wr_data = '0;
  logic [N-1:0]  inv_req, inv_ack = '0, sharers;
  logic          mem_we, locked, wr_done;
  logic [DW-1:0] mem_wdata;
  logic [NW-1:0] wr_done_node;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] exp_sh = '0;

  always #10 clk = ~clk;

  wih_home_ctrl #(.N_NODES(N), .DATA_W(DW), .NODE_W(NW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_node(wr_node), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_node(rd_node), .inv_req(inv_req),
    .inv_ack(inv_ack), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .locked(locked), .sharers(sharers), .wr_done(wr_done),
    .wr_done_node(wr_done_node)
  );

  function automatic logic [N-1:0] bit_of(input int n);
    return N'(1) << n;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic do_read(input int n);
    @(negedge clk);
    rd_valid = 1'b1; rd_node = NW'(n);
    #1 chk("R9 read ready", 32'(rd_ready), 32'd1);
    @(negedge clk);
    rd_valid = 1'b0;
    exp_sh |= bit_of(n);
    chk("R9 reader recorded", 32'(sharers), 32'(exp_sh));
  endtask

  task automatic do_write(input int node, input logic [DW-1:0] data,
                          input bit hold_rd, input int rnode, input bit spur);
    logic [N-1:0] exp_p;
    int dly[N];
    int last;
    exp_p = exp_sh & ~bit_of(node);
    last = 0;
    for (int i = 0; i < N; i++) begin
      dly[i] = 1 + int'($urandom_range(0, 4));
      if (exp_p[i] && dly[i] > last) last = dly[i];
    end
    @(negedge clk);
    wr_valid = 1'b1; wr_node = NW'(node); wr_data = data;
    if (hold_rd) begin rd_valid = 1'b1; rd_node = NW'(rnode); end
    #1 chk("R2 ready when idle", 32'(wr_ready), 32'd1);
    if (hold_rd) chk("R9 write has priority", 32'(rd_ready), 32'd0);
    @(negedge clk);
    wr_valid = 1'b0;
    #1 chk("R2 locked after accept", 32'(locked), 32'd1);
    chk("R2 no inval in lock cycle", 32'(inv_req), 32'd0);
    chk("R2 not ready while busy", 32'(wr_ready), 32'd0);
    if (hold_rd) chk("R9 read held while locked", 32'(rd_ready), 32'd0);
    if (exp_p == '0) begin
      @(negedge clk);
      chk("R6 update without inval", 32'(mem_we), 32'd1);
      chk("R6 no inval sent", 32'(inv_req), 32'd0);
    end else begin
      @(negedge clk);
      chk("R3 inval targets", 32'(inv_req), 32'(exp_p));
      chk("R4 no early update", 32'(mem_we), 32'd0);
      inv_ack = spur ? ~exp_p : '0;
      for (int t = 1; t <= last; t++) begin
        @(negedge clk);
        chk("R3 inval is one pulse", 32'(inv_req), 32'd0);
        chk("R4 update waits for acks", 32'(mem_we), 32'd0);
        if (hold_rd) chk("R9 read held while locked", 32'(rd_ready), 32'd0);
        inv_ack = spur ? ~exp_p : '0;
        for (int i = 0; i < N; i++) if (exp_p[i] && dly[i] == t) inv_ack[i] = 1'b1;
      end
      @(negedge clk);
      inv_ack = '0;
      chk(spur ? "R5 stray acks ignored" : "R4 update after last ack", 32'(mem_we), 32'd1);
    end
    chk("R10 home copy data", 32'(mem_wdata), 32'(data));
    exp_sh = bit_of(node);
    @(negedge clk);
    chk("R7 lock released", 32'(locked), 32'd0);
    chk("R7 no done yet", 32'(wr_done), 32'd0);
    chk("R8 only writer holds", 32'(sharers), 32'(exp_sh));
    if (hold_rd) chk("R9 read ready after release", 32'(rd_ready), 32'd1);
    @(negedge clk);
    if (hold_rd) begin rd_valid = 1'b0; exp_sh |= bit_of(rnode); end
    #1 chk("R7 done pulse", 32'(wr_done), 32'd1);
    chk("R7 done node", 32'(wr_done_node), 32'(node));
    if (hold_rd) chk("R9 held reader recorded", 32'(sharers), 32'(exp_sh));
    @(negedge clk);
    chk("R7 done is one pulse", 32'(wr_done), 32'd0);
    chk("R2 idle again", 32'(wr_ready), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 wr_ready", 32'(wr_ready), 32'd1);
    chk("R1 locked", 32'(locked), 32'd0);
    chk("R1 sharers", 32'(sharers), 32'd0);
    chk("R1 inv_req", 32'(inv_req), 32'd0);
    chk("R1 mem_we", 32'(mem_we), 32'd0);
    chk("R1 wr_done", 32'(wr_done), 32'd0);
    // Directed corner cases
    do_write(1, 16'hA5A5, 1'b0, 0, 1'b0);   // empty directory
    do_write(1, 16'h1234, 1'b0, 0, 1'b0);   // writer is the only holder
    do_read(0); do_read(2); do_read(3);
    do_write(2, 16'hBEEF, 1'b0, 0, 1'b0);   // writer is among the holders
    do_read(0); do_read(1); do_read(3);
    do_write(0, 16'h0F0F, 1'b0, 0, 1'b1);   // stray acks
    do_write(3, 16'h7777, 1'b1, 1, 1'b0);   // held read
    do_read(0); do_read(1); do_read(2);
    do_write(1, 16'hFFFF, 1'b1, 1, 1'b1);   // full directory, held read, stray acks
    // Constrained random mix
    for (int k = 0; k < 40; k++) begin
      if ($urandom_range(0, 2) != 0)
        do_read(int'($urandom_range(0, N-1)));
      else
        do_write(int'($urandom_range(0, N-1)), DW'($urandom),
                 ($urandom_range(0, 3) == 0), int'($urandom_range(0, N-1)),
                 ($urandom_range(0, 1) == 1));
    end
    report();
    $finish;
  end
endmodule